// File: doc/BRIEF.md
# Dual-Lane Serial ADC Capture Controller

This block is the host-side master for a simultaneous-sampling converter whose two channels shift their results out on two separate data lines. It drives an active-low chip select and a serial clock derived from the system clock. Both data lines are captured at once, on the same clock edges and under the same frame, into two shift registers. At the end of a normal frame both conversion words are presented together with a one-cycle valid strobe.

A frame is requested by a one-cycle start pulse, or by an internal period counter in free-running mode. Free-running mode spaces frames evenly so that the sampling interval is uniform. A word-length select chooses a 16-clock or a 14-clock frame. A separate mode select issues a short 8-clock burst instead. The converter interprets that burst as a power-down request, so it returns no data.

Top module: `dlane_adc_ctrl`

## Requirements
- R1: During and after reset, until the first frame, `cs_n_o` and `sclk_o` are 1, `valid_o` is 0 and both words are 0.
- R2: A start request seen on a system clock edge while idle drives `cs_n_o` low after that edge. The serial clock stays 1 whenever `cs_n_o` is 1. Within a frame, `sclk_o` makes its first falling edge DIV_HALF system clocks after `cs_n_o` falls, and then toggles every DIV_HALF system clocks.
- R3: Each falling edge of `sclk_o` captures one bit from each data line at the same instant, most significant bit first. Lane A feeds `word_a_o` and lane B feeds `word_b_o`.
- R4: With `short_word_i`=0 a frame has 16 falling edges, and with `short_word_i`=1 it has 14. `cs_n_o` rises together with the last rising edge of `sclk_o`, so it stays low for 2·N·DIV_HALF system clocks.
- R5: A 14-bit result sits in bits 13..0 of its word, and bits 15..14 are 0 (no sign extension).
- R6: `valid_o` is a single-cycle pulse in the first cycle that `cs_n_o` is high after a normal frame. Both words change only in that cycle and hold until the next normal frame.
- R7: With `pd_req_i`=1 a frame has 8 falling edges and produces no `valid_o` pulse. Both words stay unchanged. `pd_req_i` takes priority over `short_word_i`.
- R8: Between frames `cs_n_o` stays high for at least 2·DIV_HALF+1 system clocks, which is one full serial-clock period plus one idle cycle.
- R9: A start request that arrives during a frame or its gap is held. The next frame then begins exactly 2·(N+1)·DIV_HALF+1 clocks after the previous frame began. Several such requests merge into one frame.
- R10: With `free_run_i`=1 and `period_i` ≥ 2·(N+1)·DIV_HALF+1, successive falls of `cs_n_o` are exactly `period_i` system clocks apart.
- R11: Mode and length selects are latched when a frame starts. Changes during the frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle frame request |
| pd_req_i | input | 1 | 1 selects an 8-clock power-down burst |
| short_word_i | input | 1 | 1 selects a 14-clock frame, 0 a 16-clock frame |
| free_run_i | input | 1 | Enables periodic frame requests |
| period_i | input | PERIOD_W | Free-running period in system clocks |
| sdata_a_i | input | 1 | Converter data line A |
| sdata_b_i | input | 1 | Converter data line B |
| cs_n_o | output | 1 | Active-low frame / chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| word_a_o | output | WORD_W | Captured lane A word |
| word_b_o | output | WORD_W | Captured lane B word |
| valid_o | output | 1 | One-cycle strobe for both words |

## Verification
The bench drives a converter model that changes each data bit on the serial clock's rising edges. It sweeps computed word pairs, including all-ones against all-zeros and alternating end bits, through both frame lengths. A controller that sampled on the wrong edge or read LSB first would return shifted or reversed words. A controller that sign-extended would set the top bits of 14-bit results. Power-down bursts are checked for edge count, a missing strobe and untouched words, which catches a controller that treated them as normal reads.

Extra start pulses are sent during a frame to catch controllers that drop or duplicate them. Mode selects are changed mid-frame to catch controllers that decode them live. Free-running spacing is measured at the minimum legal period, where an extra idle cycle or a lost tick shows up as a wrong interval.

// File: rtl/dlane_adc_pkg.sv
package dlane_adc_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FRAME = 2'd1,
      SEQ_GAP   = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      KIND_FULL  = 2'd0,
      KIND_SHORT = 2'd1,
      KIND_PWRDN = 2'd2
   } frame_kind_e;

endpackage

// File: rtl/dlane_rate_gen.sv
module dlane_rate_gen #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                tick_o
);

   logic [PERIOD_W-1:0] cnt_q;

   // a period of zero or one fires every cycle
   assign tick_o = en_i && (PERIOD_W'(cnt_q + 1'b1) >= period_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/dlane_frame_seq.sv
module dlane_frame_seq
   import dlane_adc_pkg::*;
#(
   parameter int DIV_HALF = 2,
   parameter int WORD_W   = 16,
   parameter int SHORT_W  = 14,
   parameter int PD_W     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic pd_i,
   input  logic short_i,
   output logic cs_n_o,
   output logic sclk_o,
   output logic go_o,
   output logic smp_o,
   output logic fin_o,
   output logic pd_o
);

   localparam int HC_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam int BC_W = $clog2(WORD_W + 1);
   localparam logic [HC_W-1:0] HC_LAST = HC_W'(DIV_HALF - 1);

   seq_state_e        state_q;
   logic [HC_W-1:0]   hcnt_q;
   logic [BC_W-1:0]   rises_q;
   logic [BC_W-1:0]   target_q;
   logic              pend_q;
   logic              gap_half_q;
   logic              sclk_q;
   logic              cs_n_q;
   logic              pd_q;
   frame_kind_e       kind;
   logic [BC_W-1:0]   kind_len;
   logic              half_end;

   // power-down request outranks the length select
   always_comb begin
      if (pd_i)         kind = KIND_PWRDN;
      else if (short_i) kind = KIND_SHORT;
      else              kind = KIND_FULL;
      case (kind)
         KIND_PWRDN: kind_len = BC_W'(PD_W);
         KIND_SHORT: kind_len = BC_W'(SHORT_W);
         default:    kind_len = BC_W'(WORD_W);
      endcase
   end

   assign half_end = (hcnt_q == HC_LAST);
   assign go_o     = (state_q == SEQ_IDLE) && (req_i || pend_q);
   assign smp_o    = (state_q == SEQ_FRAME) && half_end && sclk_q;
   assign fin_o    = (state_q == SEQ_FRAME) && half_end && !sclk_q &&
                     (BC_W'(rises_q + 1'b1) == target_q);
   assign cs_n_o   = cs_n_q;
   assign sclk_o   = sclk_q;
   assign pd_o     = pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         hcnt_q     <= '0;
         rises_q    <= '0;
         target_q   <= '0;
         pend_q     <= 1'b0;
         gap_half_q <= 1'b0;
         sclk_q     <= 1'b1;
         cs_n_q     <= 1'b1;
         pd_q       <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (go_o) begin
                  state_q  <= SEQ_FRAME;
                  cs_n_q   <= 1'b0;
                  pend_q   <= 1'b0;
                  hcnt_q   <= '0;
                  rises_q  <= '0;
                  target_q <= kind_len;
                  pd_q     <= pd_i;
               end
            end
            SEQ_FRAME: begin
               if (req_i) pend_q <= 1'b1;
               if (half_end) begin
                  hcnt_q <= '0;
                  sclk_q <= ~sclk_q;
                  if (!sclk_q) begin
                     rises_q <= rises_q + 1'b1;
                     if (fin_o) begin
                        cs_n_q  <= 1'b1;
                        state_q <= SEQ_GAP;
                     end
                  end
               end else begin
                  hcnt_q <= hcnt_q + 1'b1;
               end
            end
            SEQ_GAP: begin
               if (req_i) pend_q <= 1'b1;
               if (half_end) begin
                  hcnt_q     <= '0;
                  gap_half_q <= ~gap_half_q;
                  if (gap_half_q) state_q <= SEQ_IDLE;
               end else begin
                  hcnt_q <= hcnt_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dlane_lane_shift.sv
module dlane_lane_shift #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              smp_i,
   input  logic              load_i,
   input  logic              sdata_i,
   output logic [WORD_W-1:0] word_o
);

   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] word_q;

   // cleared per frame, so short words come out zero-filled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (clr_i) begin
         sh_q <= '0;
      end else if (smp_i) begin
         sh_q <= {sh_q[WORD_W-2:0], sdata_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (load_i) begin
         word_q <= sh_q;
      end
   end

   assign word_o = word_q;

endmodule

// File: rtl/dlane_adc_ctrl.sv
module dlane_adc_ctrl #(
   parameter int DIV_HALF    = 2,
   parameter int WORD_W      = 16,
   parameter int SHORT_W     = 14,
   parameter int PD_W        = 8,
   parameter int PERIOD_W    = 16,
   parameter bit FREE_RUN_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                pd_req_i,
   input  logic                short_word_i,
   input  logic                free_run_i,
   input  logic [PERIOD_W-1:0] period_i,
   input  logic                sdata_a_i,
   input  logic                sdata_b_i,
   output logic                cs_n_o,
   output logic                sclk_o,
   output logic [WORD_W-1:0]   word_a_o,
   output logic [WORD_W-1:0]   word_b_o,
   output logic                valid_o
);

   localparam int LANES = 2;

   if (DIV_HALF < 1) begin : g_bad_div
      $error("DIV_HALF must be at least 1");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (SHORT_W < 1 || SHORT_W > WORD_W) begin : g_bad_short
      $error("SHORT_W must lie in 1..WORD_W");
   end
   if (PD_W < 1 || PD_W > WORD_W) begin : g_bad_pd
      $error("PD_W must lie in 1..WORD_W");
   end

   logic tick;
   logic req;
   logic go;
   logic smp;
   logic fin;
   logic pd_act;
   logic valid_q;
   logic [LANES-1:0]  lane_in;
   logic [WORD_W-1:0] lane_word [LANES];

   if (FREE_RUN_EN) begin : g_rate
      dlane_rate_gen #(
         .PERIOD_W (PERIOD_W)
      ) u_rate (
         .clk      (clk),
         .rst_n    (rst_n),
         .en_i     (free_run_i),
         .period_i (period_i),
         .tick_o   (tick)
      );
   end else begin : g_no_rate
      assign tick = 1'b0;
   end

   assign req = start_i || tick;

   dlane_frame_seq #(
      .DIV_HALF (DIV_HALF),
      .WORD_W   (WORD_W),
      .SHORT_W  (SHORT_W),
      .PD_W     (PD_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .pd_i    (pd_req_i),
      .short_i (short_word_i),
      .cs_n_o  (cs_n_o),
      .sclk_o  (sclk_o),
      .go_o    (go),
      .smp_o   (smp),
      .fin_o   (fin),
      .pd_o    (pd_act)
   );

   assign lane_in = {sdata_b_i, sdata_a_i};

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dlane_lane_shift #(
         .WORD_W (WORD_W)
      ) u_shift (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_i   (go),
         .smp_i   (smp),
         .load_i  (fin && !pd_act),
         .sdata_i (lane_in[g]),
         .word_o  (lane_word[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= fin && !pd_act;
   end

   assign word_a_o = lane_word[0];
   assign word_b_o = lane_word[1];
   assign valid_o  = valid_q;

endmodule

// File: rtl/dlane_adc_chk.sv
module dlane_adc_chk #(
   parameter int DIV_HALF = 2,
   parameter int WORD_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n_o,
   input logic              sclk_o,
   input logic              valid_o,
   input logic [WORD_W-1:0] word_a_o,
   input logic [WORD_W-1:0] word_b_o
);

   localparam int GAP_MIN = 2 * DIV_HALF;
   localparam int GAP_W   = $clog2(GAP_MIN + 1);

   logic [GAP_W-1:0] gap_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          gap_cnt_q <= GAP_W'(GAP_MIN);
      else if (!cs_n_o)                    gap_cnt_q <= '0;
      else if (gap_cnt_q < GAP_W'(GAP_MIN)) gap_cnt_q <= gap_cnt_q + 1'b1;
   end

   // R2
   idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sclk_o);

   // R2
   clock_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk_o) |-> !$past(cs_n_o));

   // R6
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R6
   valid_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $rose(cs_n_o));

   // R6
   words_move_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(word_a_o) || !$stable(word_b_o)) |-> valid_o);

   // R8
   frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> (gap_cnt_q == GAP_W'(GAP_MIN)));

endmodule

bind dlane_adc_ctrl dlane_adc_chk #(
   .DIV_HALF (DIV_HALF),
   .WORD_W   (WORD_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n_o   (cs_n_o),
   .sclk_o   (sclk_o),
   .valid_o  (valid_o),
   .word_a_o (word_a_o),
   .word_b_o (word_b_o)
);

// File: tb/tb_dlane_adc_ctrl.sv
module tb_dlane_adc_ctrl;

   localparam int DH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        pd_req_i = 1'b0;
   logic        short_word_i = 1'b0;
   logic        free_run_i = 1'b0;
   logic [15:0] period_i = 16'd0;
   logic        sdata_a_i = 1'b0;
   logic        sdata_b_i = 1'b0;
   logic        cs_n_o;
   logic        sclk_o;
   logic [15:0] word_a_o;
   logic [15:0] word_b_o;
   logic        valid_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [15:0] drv_a = '0;
   logic [15:0] drv_b = '0;
   int nbits = 16;

   int cyc = 0, frames = 0, falls = 0, low_len = 0, first_delay = 0;
   int last_fall_cyc = 0, spacing = 0, rise_cyc = -1, bit_idx = 0;
   int valid_cnt = 0, valid_bad = 0;
   logic prev_cs = 1'b1, prev_sclk = 1'b1;

   always #2 clk = ~clk;

   dlane_adc_ctrl dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .pd_req_i     (pd_req_i),
      .short_word_i (short_word_i),
      .free_run_i   (free_run_i),
      .period_i     (period_i),
      .sdata_a_i    (sdata_a_i),
      .sdata_b_i    (sdata_b_i),
      .cs_n_o       (cs_n_o),
      .sclk_o       (sclk_o),
      .word_a_o     (word_a_o),
      .word_b_o     (word_b_o),
      .valid_o      (valid_o)
   );

   // converter model and frame monitor, sampled away from the rising edge
   always @(negedge clk) begin
      cyc++;
      if (prev_cs && !cs_n_o) begin
         frames++;
         spacing = cyc - last_fall_cyc;
         last_fall_cyc = cyc;
         falls = 0;
         low_len = 0;
         bit_idx = 0;
         first_delay = -1;
      end
      if (!prev_cs && cs_n_o) rise_cyc = cyc;
      if (!cs_n_o) low_len++;
      if (prev_sclk && !sclk_o) begin
         falls++;
         if (falls == 1) first_delay = cyc - last_fall_cyc;
      end
      if (!prev_sclk && sclk_o) bit_idx++;
      if (valid_o) begin
         valid_cnt++;
         if (cyc != rise_cyc) valid_bad++;
      end
      sdata_a_i = (bit_idx < nbits) ? drv_a[nbits-1-bit_idx] : 1'b0;
      sdata_b_i = (bit_idx < nbits) ? drv_b[nbits-1-bit_idx] : 1'b0;
      prev_cs = cs_n_o;
      prev_sclk = sclk_o;
   end

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] pat_a(input int i);
      if (i == 0) return 16'hFFFF;
      if (i == 1) return 16'h8001;
      return 16'(i * 16'h3B1D + 16'hA5C3);
   endfunction

   function automatic logic [15:0] pat_b(input int i);
      logic [15:0] a;
      if (i == 0) return 16'h0000;
      if (i == 1) return 16'h7FFE;
      a = pat_a(i);
      return {a[6:0], a[15:7]} ^ 16'h0F0F;
   endfunction

   task automatic pulse_start();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_frame(input logic pd, input logic sh,
                            input logic [15:0] a, input logic [15:0] b);
      int f0, v0, n;
      logic [15:0] wa0, wb0, mask;
      n = pd ? 8 : (sh ? 14 : 16);
      mask = 16'((32'd1 << n) - 1);
      @(negedge clk);
      drv_a = a; drv_b = b; nbits = n;
      pd_req_i = pd; short_word_i = sh;
      f0 = frames; v0 = valid_cnt; wa0 = word_a_o; wb0 = word_b_o;
      pulse_start();
      repeat (2 * (n + 1) * DH + 4) @(negedge clk);
      chk("R2", "frame count", frames, f0 + 1);
      chk("R2", "first sclk fall delay", first_delay, DH);
      if (pd) begin
         chk("R7", "pd falling edges", falls, 8);
         chk("R7", "pd cs low cycles", low_len, 2 * 8 * DH);
         chk("R7", "pd valid pulses", valid_cnt, v0);
         chk("R7", "pd word a held", word_a_o, wa0);
         chk("R7", "pd word b held", word_b_o, wb0);
      end else begin
         chk("R4", "falling edges", falls, n);
         chk("R4", "cs low cycles", low_len, 2 * n * DH);
         chk("R6", "valid pulses", valid_cnt, v0 + 1);
         chk("R6", "valid misplaced", valid_bad, 0);
         chk(sh ? "R5" : "R3", "word a", word_a_o, a & mask);
         chk(sh ? "R5" : "R3", "word b", word_b_o, b & mask);
      end
   endtask

   task automatic free_run_test(input int p);
      int f0;
      @(negedge clk);
      pd_req_i = 1'b0; short_word_i = 1'b0; nbits = 16;
      period_i = 16'(p);
      free_run_i = 1'b1;
      for (int k = 0; k < 5; k++) begin
         f0 = frames;
         while (frames == f0) @(negedge clk);
         if (k >= 1) chk("R10", "free-run spacing", spacing, p);
      end
      free_run_i = 1'b0;
      repeat (3 * p) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int f0, v0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "cs_n in reset", cs_n_o, 1);
      chk("R1", "sclk in reset", sclk_o, 1);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1", "cs_n after reset", cs_n_o, 1);
      chk("R1", "sclk after reset", sclk_o, 1);
      chk("R1", "valid after reset", valid_o, 0);
      chk("R1", "word a after reset", word_a_o, 0);
      chk("R1", "word b after reset", word_b_o, 0);

      // R3 R4 R5: sweep of patterns over both frame lengths
      for (int i = 0; i < 12; i++) begin
         for (int s = 0; s < 2; s++) begin
            run_frame(1'b0, s[0], pat_a(i), pat_b(i));
         end
      end

      // R7: power-down bursts, also with the short select set
      for (int i = 0; i < 3; i++) begin
         run_frame(1'b1, i[0], pat_b(i + 5), pat_a(i + 5));
      end

      // R11: selects changed in mid-frame are ignored
      @(negedge clk);
      drv_a = 16'hC3A5; drv_b = 16'h1E2D; nbits = 16;
      pd_req_i = 1'b0; short_word_i = 1'b0;
      v0 = valid_cnt;
      pulse_start();
      repeat (8) @(negedge clk);
      pd_req_i = 1'b1; short_word_i = 1'b1;
      repeat (2 * 17 * DH + 4) @(negedge clk);
      chk("R11", "edges after mid-frame change", falls, 16);
      chk("R11", "valid after mid-frame change", valid_cnt, v0 + 1);
      chk("R11", "word a after mid-frame change", word_a_o, 16'hC3A5);
      chk("R11", "word b after mid-frame change", word_b_o, 16'h1E2D);
      pd_req_i = 1'b0; short_word_i = 1'b0;

      // R9 R8: requests during a frame are held and merged
      @(negedge clk);
      f0 = frames;
      pulse_start();
      repeat (10) @(negedge clk);
      pulse_start();
      repeat (30) @(negedge clk);
      pulse_start();
      repeat (200) @(negedge clk);
      chk("R9", "frames from held requests", frames, f0 + 2);
      chk("R9", "held request spacing", spacing, 2 * 17 * DH + 1);
      chk("R8", "gap cycles", spacing - 2 * 16 * DH, 2 * DH + 1);

      // R10: uniform spacing, at a roomy and at the minimum period
      free_run_test(80);
      free_run_test(2 * 17 * DH + 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule